// File: doc/BRIEF.md
# Routed Interrupt Aggregator

This block collects thirty-two level-held interrupt requests from the devices of a chip and merges them onto a small set of output lines toward a processor's interrupt controller. Software gives each request its own enable bit. It also gives each request a 4-bit route code that selects one output line or none. Every output line is the OR of all enabled, asserted requests routed to it. Because requests stay high until the device is serviced, the block keeps no pending state. It has no edge capture, no priority logic and no acknowledge.

Software reaches the block over a plain 32-bit register bus with byte addresses. The enable word sits at 0x00. A read-only snapshot of the input levels sits at 0x04. Four route words sit at 0x08, 0x0C, 0x10 and 0x14. Each route word packs eight 4-bit codes, and the words run in reverse source order: the word at 0x14 carries sources 0 to 7 and the word at 0x08 carries sources 24 to 31.

Top module: `irq_router`

## Requirements
- R1: While reset is held and at its release, the enable word, every route code and every output line are zero, and reads of all six registers return zero when no input is asserted.
- R2: A write to offset 0x00 sets the enable word to the written value (bit n enables source n), and a read of 0x00 returns it.
- R3: A read of offset 0x04 returns the input levels sampled at the previous clock edge, whatever the enable word and route codes hold; writes to 0x04 change nothing.
- R4: The route code of source n sits in the word at offset 0x08 + 4·(3 − n/8), in bits 4·(n mod 8) to 4·(n mod 8)+3; reads of that word return the stored codes.
- R5: A source whose route code is 0 drives no output line.
- R6: A source with route code c (1 to 15), enable bit 1 and input high drives output line c−1. Outputs are registered, so an input change appears on the outputs one clock edge later.
- R7: Each output line is the OR of every enabled, asserted source routed to it, and it stays asserted as long as any such source stays high.
- R8: A source whose enable bit is 0 drives no output line; an enable word of zero holds every output line low.
- R9: A write to one route word replaces all eight codes in that word and leaves the other three words unchanged.
- R10: Reads of offsets above 0x14, or of addresses not aligned to four bytes, return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_in | input | 32 | Level interrupt requests, bit n is source n |
| bus_addr | input | 8 | Register byte address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_out | output | 15 | Output interrupt lines, line k driven by route code k+1 |

## Verification
The bench builds the block with its default values: 32 sources, 4-bit codes and 15 output lines. This keeps the space small enough to sweep every source against every route code, 512 pairs, each with a readback of the packed route word. The full field placement and the whole code-to-line map are therefore covered, not sampled. A seeded pseudo-random phase then loads all four route words and the enable word together, so that many sources share lines. This reaches the OR merging, the level holding and the per-bit enable gating under dense overlap.

// File: rtl/irq_router.sv
module irq_router #(
  parameter int NSRC   = 32,
  parameter int CODE_W = 4,
  parameter int NOUT   = 15,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   irq_in,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [NOUT-1:0]   irq_out
);
  localparam int FPR   = DATA_W / CODE_W;
  localparam int NREG  = NSRC / FPR;
  localparam int WA_W  = ADDR_W - 2;
  localparam int W_MSK = 0;
  localparam int W_STA = 1;
  localparam int W_RT0 = 2;

  logic [NSRC-1:0]   src_q;
  logic [NSRC-1:0]   mask_q;
  logic [CODE_W-1:0] route_q [NSRC];
  logic [NOUT-1:0]   hit;
  logic [NOUT-1:0]   out_q;

  wire [WA_W-1:0] word    = bus_addr[ADDR_W-1:2];
  wire            aligned = (bus_addr[1:0] == 2'b00);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) src_q <= '0;
    else        src_q <= irq_in;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                                         mask_q <= '0;
    else if (bus_wr && aligned && word == WA_W'(W_MSK)) mask_q <= bus_wdata[NSRC-1:0];

  for (genvar n = 0; n < NSRC; n++) begin : g_src
    localparam int RIDX = NREG - 1 - n / FPR;
    localparam int FLD  = n % FPR;
    wire sel = bus_wr && aligned && (word == WA_W'(W_RT0 + RIDX));
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)   route_q[n] <= '0;
      else if (sel) route_q[n] <= bus_wdata[FLD*CODE_W +: CODE_W];
  end

  always_comb begin
    hit = '0;
    for (int k = 0; k < NOUT; k++)
      for (int n = 0; n < NSRC; n++)
        if (irq_in[n] && mask_q[n] && route_q[n] == CODE_W'(k + 1)) hit[k] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) out_q <= '0;
    else        out_q <= hit;

  assign irq_out = out_q;

  always_comb begin
    bus_rdata = '0;
    if (aligned) begin
      if (word == WA_W'(W_MSK)) bus_rdata[NSRC-1:0] = mask_q;
      if (word == WA_W'(W_STA)) bus_rdata[NSRC-1:0] = src_q;
      for (int r = 0; r < NREG; r++)
        if (word == WA_W'(W_RT0 + r))
          for (int f = 0; f < FPR; f++)
            bus_rdata[f*CODE_W +: CODE_W] = route_q[(NREG-1-r)*FPR + f];
    end
  end
endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk #(
  parameter int NSRC   = 32,
  parameter int NOUT   = 15,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NSRC-1:0]   irq_in,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [NOUT-1:0]   irq_out,
  input logic [NSRC-1:0]   mask_q
);
  logic live;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) live <= 1'b0;
    else        live <= 1'b1;

  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_n |=> irq_out == '0);

  a_r2_mask_write: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == '0) |=> mask_q == $past(bus_wdata[NSRC-1:0]));

  a_r3_status_raw: assert property (@(posedge clk) disable iff (!rst_n)
    (live && bus_addr == ADDR_W'(4)) |-> bus_rdata[NSRC-1:0] == $past(irq_in));

  a_r6_no_input_no_output: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_in == '0) |=> irq_out == '0);

  a_r8_mask_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |=> irq_out == '0);

  a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr[1:0] != 2'b00 || bus_addr > ADDR_W'(20)) |-> bus_rdata == '0);
endmodule

bind irq_router irq_router_chk #(
  .NSRC(NSRC), .NOUT(NOUT), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_addr(bus_addr),
  .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .irq_out(irq_out), .mask_q(mask_q)
);

// File: tb/test_irq_router.sv
`timescale 1ns/1ps
module test_irq_router;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] irq_in = '0;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [14:0] irq_out;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [31:0] bm_mask = '0;
  logic [3:0]  bm_route [32];
  logic [31:0] seed = 32'h1234_5678;

  always #2.5 clk = ~clk;

  irq_router i_irq_router (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq_out)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] nxt();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
    return seed;
  endfunction

  function automatic logic [14:0] exp_out(input logic [31:0] lv);
    logic [14:0] o = '0;
    for (int n = 0; n < 32; n++)
      if (lv[n] && bm_mask[n] && bm_route[n] != 0) o[bm_route[n]-1] = 1'b1;
    return o;
  endfunction

  function automatic logic [31:0] exp_word(input int r);
    logic [31:0] w = '0;
    for (int f = 0; f < 8; f++) w[4*f +: 4] = bm_route[(3-r)*8 + f];
    return w;
  endfunction

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
    if (a == 8'h00) bm_mask = d;
    if (a >= 8'h08 && a <= 8'h14 && a[1:0] == 2'b00)
      for (int f = 0; f < 8; f++) bm_route[(3 - (a - 8) / 4) * 8 + f] = d[4*f +: 4];
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string req);
    bus_addr = a; #0.5;
    check(req, bus_rdata, exp);
  endtask

  task automatic drive(input logic [31:0] lv);
    @(negedge clk); irq_in = lv;
    @(negedge clk);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] lv, keep;
    for (int n = 0; n < 32; n++) bm_route[n] = '0;
    repeat (3) @(negedge clk);
    // R1 reset values
    check("R1 out in reset", {17'b0, irq_out}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int a = 0; a <= 20; a += 4) rd(8'(a), 32'h0, "R1 reg after reset");
    check("R1 out after reset", {17'b0, irq_out}, 32'h0);

    // R10 unmapped and misaligned
    rd(8'h18, 0, "R10 above map"); rd(8'hFC, 0, "R10 top"); rd(8'h02, 0, "R10 misaligned");
    rd(8'h09, 0, "R10 misaligned route");

    // R2 enable word
    wr(8'h00, 32'hA5A5_0F0F); rd(8'h00, 32'hA5A5_0F0F, "R2 mask readback");
    wr(8'h00, 32'h5A5A_F0F0); rd(8'h00, 32'h5A5A_F0F0, "R2 mask readback");
    wr(8'h00, 32'h0);

    // R3 status raw, ignores mask, routing, writes; R8 zero mask blocks
    wr(8'h08, 32'h1111_1111);
    drive(32'hDEAD_BEEF); rd(8'h04, 32'hDEAD_BEEF, "R3 status raw");
    check("R8 zero mask", {17'b0, irq_out}, 32'h0);
    wr(8'h04, 32'h0); rd(8'h04, 32'hDEAD_BEEF, "R3 status write ignored");
    drive(32'h0000_0001); rd(8'h04, 32'h1, "R3 status raw");
    wr(8'h08, 32'h0);

    // R4/R5/R6 exhaustive source x code sweep
    wr(8'h00, 32'hFFFF_FFFF);
    for (int n = 0; n < 32; n++) begin
      for (int c = 0; c < 16; c++) begin
        wr(8'(8 + 4 * (3 - n / 8)), 32'(c) << (4 * (n % 8)));
        drive(32'h1 << n);
        check(c == 0 ? "R5 code zero" : "R6 code to line",
              {17'b0, irq_out}, c == 0 ? 32'h0 : 32'h1 << (c - 1));
        if (c == 15)
          for (int r = 0; r < 4; r++) rd(8'(8 + 4 * r), exp_word(r), "R4 field placement");
        drive(32'h0);
      end
      wr(8'(8 + 4 * (3 - n / 8)), 32'h0);
    end

    // R6 one-edge latency
    wr(8'h14, 32'h0000_0003);
    @(negedge clk); irq_in = 32'h1; #1;
    check("R6 before edge", {17'b0, irq_out}, 32'h0);
    @(negedge clk);
    check("R6 after one edge", {17'b0, irq_out}, 32'h4);
    irq_in = 32'h0;

    // R9 isolation of route words
    wr(8'h08, 32'h1234_5678); wr(8'h0C, 32'h9ABC_DEF0);
    wr(8'h10, 32'h0FED_CBA9); wr(8'h14, 32'h8765_4321);
    wr(8'h10, 32'hCAFE_F00D);
    rd(8'h08, 32'h1234_5678, "R9 other word kept");
    rd(8'h0C, 32'h9ABC_DEF0, "R9 other word kept");
    rd(8'h10, 32'hCAFE_F00D, "R9 word replaced");
    rd(8'h14, 32'h8765_4321, "R9 other word kept");

    // R7/R8 dense random overlap and level holding
    for (int i = 0; i < 300; i++) begin
      for (int r = 0; r < 4; r++) wr(8'(8 + 4 * r), nxt());
      wr(8'h00, nxt() | nxt());
      lv = nxt() & nxt();
      drive(lv);
      check("R7 OR merge", {17'b0, irq_out}, {17'b0, exp_out(lv)});
      keep = {17'b0, exp_out(lv)};
      @(negedge clk);
      check("R7 level held", {17'b0, irq_out}, keep);
      if (i % 10 == 0) begin
        wr(8'h00, bm_mask & ~lv);
        @(negedge clk);
        check("R8 mask bit blocks", {17'b0, irq_out}, 32'h0);
      end
    end

    drive(32'h0);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule